// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat burst into a synchronous memory array. Either of two load strobes captures a full external address. One strobe comes from the processor side and the other from the memory controller side. The captured upper bits stay fixed until the next load. The two low bits then move through four offsets, one step for each cycle in which the advance input is high.

The offsets follow one of two orders. In wrapping order the offset counts upward modulo four from the start offset. In exclusive-or order it is the start offset XOR the beat number. The order input is captured together with the address, so it holds for the whole burst. A system that does not use bursts can assert a strobe on every cycle, and the output then follows the external address with one register of delay.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, addr_out is all zeros and beat is 0. The captured order is exclusive-or order (order_lin = 0).
- R2: A clock edge with proc_strobe or ctrl_strobe high (or both) loads addr_in. After that edge addr_out equals addr_in and beat is 0.
- R3: A clock edge with no strobe and advance high increments beat modulo 4. A clock edge with no strobe and advance low leaves addr_out and beat unchanged.
- R4: When order_lin was 1 at the load, addr_out[1:0] equals (start + beat) mod 4, where start is addr_in[1:0] at the load.
- R5: When order_lin was 0 at the load, addr_out[1:0] equals start XOR beat.
- R6: order_lin is sampled only on a load edge. Changing it during a burst has no effect on later addresses.
- R7: addr_out[ADDR_W-1:2] stays equal to the loaded upper bits until the next load. addr_in is ignored on edges without a strobe.
- R8: A strobe during a burst reloads the address and restarts beat at 0. A strobe takes priority over advance on the same edge.
- R9: After four advances the low bits return to the start offset and beat returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strobe | input | 1 | Processor-side address load |
| ctrl_strobe | input | 1 | Controller-side address load |
| advance | input | 1 | Step to the next beat |
| order_lin | input | 1 | 1 = wrapping order, 0 = exclusive-or order; sampled on load |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Address to the memory array |
| beat | output | 2 | Beat number within the current burst |

## Verification
All sequencer state appears at addr_out on the cycle after it changes, because the low bits are a pure function of the held start offset, the captured order and the beat count. A beat count that skips, sticks or misses the wrap shows up in addr_out[1:0] on the very next edge. A wrong captured order shows up on the first advance after a load whose start offset is odd. A corrupted upper field, or one that follows addr_in without a strobe, differs from the expected address on the first such edge.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_XOR  = 1'b0,
    ORD_WRAP = 1'b1
  } order_e;

  // low-bit offset for beat n of a burst that started at offset s
  function automatic logic [BEAT_W-1:0] map_offset(
    input order_e             ord,
    input logic [BEAT_W-1:0]  s,
    input logic [BEAT_W-1:0]  n
  );
    logic [BEAT_W-1:0] r;
    if (ord == ORD_WRAP) r = s + n;
    else                 r = s ^ n;
    return r;
  endfunction

  function automatic logic [BEAT_W-1:0] next_beat(input logic [BEAT_W-1:0] n);
    return n + 1'b1;
  endfunction
endpackage

// File: rtl/bseq_beat_count.sv
module bseq_beat_count
  import bseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= next_beat(beat);
  end
endmodule

// File: rtl/bseq_base_hold.sv
module bseq_base_hold
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int UP_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_in,
  output logic [UP_W-1:0]   upper,
  output logic [BEAT_W-1:0] start_low,
  output order_e            order_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper     <= '0;
      start_low <= '0;
      order_q   <= ORD_XOR;
    end else if (load) begin
      upper     <= addr_in[ADDR_W-1:BEAT_W];
      start_low <= addr_in[BEAT_W-1:0];
      order_q   <= order_e'(order_in);
    end
  end
endmodule

// File: rtl/bseq_offset_map.sv
module bseq_offset_map
  import bseq_pkg::*;
(
  input  order_e            order_q,
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);
  always_comb low = map_offset(order_q, start_low, beat);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              advance,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat
);
  localparam int UP_W = ADDR_W - BEAT_W;

  // named internal events for the checker
  logic              load_evt;
  logic              step_evt;
  logic [UP_W-1:0]   upper;
  logic [BEAT_W-1:0] start_low;
  logic [BEAT_W-1:0] low;
  logic [BEAT_W-1:0] beat_q;
  order_e            order_q;

  assign load_evt = proc_strobe | ctrl_strobe;
  assign step_evt = advance & ~load_evt;

  bseq_beat_count u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .step  (advance),
    .beat  (beat_q)
  );

  bseq_base_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .addr_in   (addr_in),
    .order_in  (order_lin),
    .upper     (upper),
    .start_low (start_low),
    .order_q   (order_q)
  );

  bseq_offset_map u_map (
    .order_q   (order_q),
    .start_low (start_low),
    .beat      (beat_q),
    .low       (low)
  );

  assign addr_out = {upper, low};
  assign beat     = beat_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_evt,
  input logic              step_evt,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat,
  input logic [BEAT_W-1:0] start_low,
  input order_e            order_q
);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_out == $past(addr_in)) && (beat == 2'd0));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat == $past(beat) + 2'd1);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> $stable(addr_out) && $stable(beat));

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  // R9
  start_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat == 2'd0) |-> addr_out[BEAT_W-1:0] == start_low);

  // R6
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(order_q));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_evt  (load_evt),
  .step_evt  (step_evt),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .beat      (beat),
  .start_low (start_low),
  .order_q   (order_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int NV = 19;

  // entry: {proc, ctrl, adv, lin, addr_in[19:0], expected[19:0]}
  localparam logic [43:0] VEC [NV] = '{
    {4'b1001, 20'h12346, 20'h12346},  // R2 R4 load start=2 wrap order
    {4'b0011, 20'h00000, 20'h12347},  // R4 2+1
    {4'b0011, 20'h00000, 20'h12344},  // R4 2+2
    {4'b0001, 20'h00000, 20'h12344},  // R3 hold
    {4'b0011, 20'h00000, 20'h12345},  // R4 2+3
    {4'b0011, 20'h00000, 20'h12346},  // R9 wrap
    {4'b0100, 20'hABCD1, 20'hABCD1},  // R2 R5 load start=1 xor order
    {4'b0011, 20'h00000, 20'hABCD0},  // R6 lin change ignored, 1^1
    {4'b0010, 20'h00000, 20'hABCD3},  // R5 1^2
    {4'b0010, 20'h00000, 20'hABCD2},  // R5 1^3
    {4'b0010, 20'h00000, 20'hABCD1},  // R9 wrap
    {4'b0010, 20'h55555, 20'hABCD0},  // R7 addr_in ignored
    {4'b1011, 20'h0F00F, 20'h0F00F},  // R8 strobe beats advance
    {4'b0011, 20'h00000, 20'h0F00C},  // R4 3+1 mod 4
    {4'b1100, 20'h77772, 20'h77772},  // R2 both strobes
    {4'b0010, 20'h00000, 20'h77773},  // R5 2^1
    {4'b0010, 20'h00000, 20'h77770},  // R5 2^2
    {4'b0101, 20'h00003, 20'h00003},  // R8 mid-burst restart
    {4'b0011, 20'h00000, 20'h00000}   // R4 3+1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_strobe = 1'b0, ctrl_strobe = 1'b0, advance = 1'b0, order_lin = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe),
    .advance(advance), .order_lin(order_lin), .addr_in(addr_in),
    .addr_out(addr_out), .beat(beat)
  );

  function automatic string vec_req(input int i);
    case (i)
      0, 6, 14: return "R2";
      3:        return "R3";
      5, 10:    return "R9";
      7:        return "R6";
      11:       return "R7";
      12, 17:   return "R8";
      8, 9, 15, 16: return "R5";
      default:  return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    {proc_strobe, ctrl_strobe, advance, order_lin} = c;
    addr_in = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1 reset state
    drive(4'b1011, 20'hFFFFF);
    drive(4'b0000, 20'h00000);
    check("R1 addr", addr_out, '0);
    check("R1 beat", {18'd0, beat}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: first advance after reset uses start 0 in xor order
    drive(4'b0010, 20'h00000);
    check("R1 beat after advance", {18'd0, beat}, 20'd1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][43:40], VEC[i][39:20]);
      check(vec_req(i), addr_out, VEC[i][19:0]);
    end

    // R9: four advances bring beat back to 0
    drive(4'b1000, 20'h00C02);
    for (int k = 0; k < 4; k++) drive(4'b0010, 20'h00000);
    check("R9 beat", {18'd0, beat}, '0);
    check("R9 addr", addr_out, 20'h00C02);

    // R3: advance low leaves beat unchanged
    drive(4'b0010, 20'h00000);
    drive(4'b0000, 20'h00000);
    check("R3 beat hold", {18'd0, beat}, 20'd1);

    // R1: reset mid-burst clears state
    @(negedge clk);
    rst_n = 1'b0;
    drive(4'b0010, 20'h00000);
    check("R1 mid-burst reset", addr_out, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule